// File: doc/BRIEF.md
# USB Host Interrupt Status Unit

This block holds the byte-wide interrupt status of a small USB host controller. It latches done events from two packet engines (A and B), the 1-ms frame timer tick, and cable attach or detach events. It also reports either a latched resume event or the device-present level, and it shows the live level of the D+ line. Software reads the byte over a simple register bus. It clears pending flags by writing ones to their positions. A single interrupt output stays high while any enabled flag is pending.

Attach and detach come from the bus line state. The D+ and D- inputs are synchronized and decoded into SE0, J, K or SE1. A new state is accepted only after the raw state has stayed unchanged for a configurable number of clocks. A change of the accepted state from SE0 to IDLE (J for the current speed) flags an attach. A change from IDLE to SE0 flags a detach. Both events set the same bit.

Top module: `usbh_irq_status`

## Requirements
- R1: After reset, bits 0, 1, 4 and 5 read 0 and `irq` is 0. The accepted line state resets to SE0, so bit 6 reads 1 when `resume_mode` is 0.
- R2: A one-cycle pulse on `done_a` sets bit 0 and a pulse on `done_b` sets bit 1. Each bit is readable one clock later.
- R3: A pulse on `frame_tick` sets bit 4.
- R4: A write (`reg_wr`=1) clears every latched bit (0, 1, 4, 5, 6) whose `reg_wdata` bit is 1. Bits written 0 keep their value.
- R5: If a set event and a write-1 clear of the same bit happen in the same cycle, the bit ends up set.
- R6: Bit 5 sets when the accepted line state moves from SE0 to IDLE or from IDLE to SE0. SE0 is D+=0, D-=0. IDLE is D+=1, D-=0 when `low_speed`=0, and D+=0, D-=1 when `low_speed`=1.
- R7: A raw line state held for fewer than STABLE_CLKS clocks is never accepted. A move from SE0 to K and then from K to IDLE sets no bit 5.
- R8: When `resume_mode`=1, bit 6 is a latched flag that a pulse on `resume_evt` sets.
- R9: When `resume_mode`=0, bit 6 reads 1 while the accepted line state is SE0 and 0 otherwise. In this mode `resume_evt` is ignored.
- R10: Bit 7 reads the level of `usb_dp` after SYNC_STAGES clocks of synchronization.
- R11: Bits 2 and 3 always read 0. Writing them has no effect.
- R12: `irq` is 1 exactly when any of bits 0, 1, 4 or 5 is set, or when bit 6 is set with `resume_mode`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the status register |
| reg_wdata | input | 8 | Write data; a 1 clears the matching pending bit |
| status_rdata | output | 8 | Current status byte |
| irq | output | 1 | High while an enabled flag is pending |
| done_a | input | 1 | Done pulse from packet engine A |
| done_b | input | 1 | Done pulse from packet engine B |
| frame_tick | input | 1 | 1-ms frame timer pulse |
| resume_evt | input | 1 | Resume detection pulse |
| resume_mode | input | 1 | 1: bit 6 is resume flag; 0: bit 6 is no-device level |
| low_speed | input | 1 | Selects which line state counts as IDLE |
| usb_dp | input | 1 | Asynchronous D+ line |
| usb_dm | input | 1 | Asynchronous D- line |

## Verification
The assertions assume that the event inputs and `reg_wr` are synchronous single-cycle pulses. They also assume that `resume_mode` and `low_speed` change only while the line is quiet. The bench drives every input on the falling edge. It holds both mode inputs fixed across each sweep, and it changes `usb_dp` and `usb_dm` only at held levels or in glitches of a defined length, so every line check is made after the filter has settled.

// File: rtl/usbh_irq_pkg.sv
package usbh_irq_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'd0,
        LS_J   = 2'd1,
        LS_K   = 2'd2,
        LS_SE1 = 2'd3
    } line_e;

    typedef struct packed {
        logic resume;
        logic conn;
        logic sof;
        logic done_b;
        logic done_a;
    } flags_t;

    localparam int BIT_DONE_A = 0;
    localparam int BIT_DONE_B = 1;
    localparam int BIT_SOF    = 4;
    localparam int BIT_CONN   = 5;
    localparam int BIT_DEV    = 6;
    localparam int BIT_DP     = 7;

endpackage

// File: rtl/usbh_line_sync.sv
module usbh_line_sync #(
    parameter int STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] raw_i,
    output logic [1:0] sync_o
);
    logic [1:0] stage_q [STAGES];
    logic [1:0] stage_d [STAGES];

    always_comb begin
        stage_d[0] = raw_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= 2'b00;
                else        stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/usbh_line_filter.sv
module usbh_line_filter
    import usbh_irq_pkg::*;
#(
    parameter int STABLE_CLKS = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  dp_i,
    input  logic  dm_i,
    input  logic  low_speed_i,
    output line_e state_o,
    output logic  attach_o,
    output logic  detach_o
);
    localparam int CNT_W   = (STABLE_CLKS > 1) ? $clog2(STABLE_CLKS) : 1;
    localparam int CNT_MAX = STABLE_CLKS - 1;

    typedef struct packed {
        line_e             cand;
        line_e             filt;
        logic [CNT_W-1:0]  cnt;
    } filt_st_t;

    filt_st_t st_d, st_q;
    line_e    raw;

    always_comb begin
        unique case ({dp_i, dm_i})
            2'b00:   raw = LS_SE0;
            2'b11:   raw = LS_SE1;
            default: raw = (dp_i != low_speed_i) ? LS_J : LS_K;
        endcase
    end

    always_comb begin
        st_d = st_q;
        if (raw != st_q.cand) begin
            st_d.cand = raw;
            st_d.cnt  = '0;
        end else if (st_q.cnt != CNT_W'(CNT_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else begin
            st_d.filt = st_q.cand;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cand: LS_SE0, filt: LS_SE0, cnt: '0};
        else        st_q <= st_d;
    end

    assign state_o  = st_q.filt;
    assign attach_o = (st_q.filt == LS_SE0) && (st_d.filt == LS_J);
    assign detach_o = (st_q.filt == LS_J)   && (st_d.filt == LS_SE0);

    // R6: attach and detach never coincide
    a_r6_one_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({attach_o, detach_o}));

    // R7: an accepted state was already the held candidate before the edge
    a_r7_commit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (st_d.filt != st_q.filt) |-> (st_q.cand == raw));
endmodule

// File: rtl/usbh_irq_regs.sv
module usbh_irq_regs
    import usbh_irq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   wr_i,
    input  logic [7:0] wdata_i,
    input  flags_t set_i,
    input  logic   resume_mode_i,
    output flags_t flags_o
);
    flags_t flags_d, flags_q;
    flags_t clr;

    always_comb begin
        clr = '0;
        if (wr_i) begin
            clr.done_a = wdata_i[BIT_DONE_A];
            clr.done_b = wdata_i[BIT_DONE_B];
            clr.sof    = wdata_i[BIT_SOF];
            clr.conn   = wdata_i[BIT_CONN];
            clr.resume = wdata_i[BIT_DEV];
        end
        flags_d = (flags_q & ~clr) | set_i;
        if (!resume_mode_i) flags_d.resume = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign flags_o = flags_q;

    // R5: an event always leaves its bit set
    a_r5_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i.done_a |=> flags_q.done_a);
    // R4: write-1 with no event clears
    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && wdata_i[BIT_DONE_B] && !set_i.done_b) |=> !flags_q.done_b);
    // R4: a pending bit holds unless cleared
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q.sof && !(wr_i && wdata_i[BIT_SOF])) |=> flags_q.sof);
endmodule

// File: rtl/usbh_irq_status.sv
module usbh_irq_status
    import usbh_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int STABLE_CLKS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] status_rdata,
    output logic       irq,
    input  logic       done_a,
    input  logic       done_b,
    input  logic       frame_tick,
    input  logic       resume_evt,
    input  logic       resume_mode,
    input  logic       low_speed,
    input  logic       usb_dp,
    input  logic       usb_dm
);
    logic [1:0] line_sync;
    line_e      line_state;
    logic       attach, detach;
    flags_t     set_ev, flags;

    usbh_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({usb_dp, usb_dm}),
        .sync_o (line_sync)
    );

    usbh_line_filter #(.STABLE_CLKS(STABLE_CLKS)) u_filter (
        .clk         (clk),
        .rst_n       (rst_n),
        .dp_i        (line_sync[1]),
        .dm_i        (line_sync[0]),
        .low_speed_i (low_speed),
        .state_o     (line_state),
        .attach_o    (attach),
        .detach_o    (detach)
    );

    always_comb begin
        set_ev        = '0;
        set_ev.done_a = done_a;
        set_ev.done_b = done_b;
        set_ev.sof    = frame_tick;
        set_ev.conn   = attach | detach;
        set_ev.resume = resume_evt & resume_mode;
    end

    usbh_irq_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_i          (reg_wr),
        .wdata_i       (reg_wdata),
        .set_i         (set_ev),
        .resume_mode_i (resume_mode),
        .flags_o       (flags)
    );

    always_comb begin
        status_rdata             = '0;
        status_rdata[BIT_DONE_A] = flags.done_a;
        status_rdata[BIT_DONE_B] = flags.done_b;
        status_rdata[BIT_SOF]    = flags.sof;
        status_rdata[BIT_CONN]   = flags.conn;
        status_rdata[BIT_DEV]    = resume_mode ? flags.resume : (line_state == LS_SE0);
        status_rdata[BIT_DP]     = line_sync[1];
    end

    assign irq = flags.done_a | flags.done_b | flags.sof | flags.conn
               | (resume_mode & flags.resume);

    // R12: a quiet interrupt line means no transfer, timer or cable flag pending
    a_r12_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq |-> (status_rdata[1:0] == 2'b00 && status_rdata[5:4] == 2'b00));
    // R2: a done pulse raises the interrupt on the next cycle
    a_r2_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (done_a || done_b) |=> irq);
endmodule

// File: tb/usbh_irq_status_bench.sv
module usbh_irq_status_bench;
    localparam int STABLE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 0, done_a = 0, done_b = 0, frame_tick = 0, resume_evt = 0;
    logic resume_mode = 1, low_speed = 0, usb_dp = 0, usb_dm = 0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] status_rdata;
    logic irq;
    int tests = 0, fails = 0;
    bit done_flag = 0;

    always #2 clk = ~clk;

    usbh_irq_status #(.SYNC_STAGES(2), .STABLE_CLKS(STABLE)) u_usbh_irq_status (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .status_rdata(status_rdata), .irq(irq), .done_a(done_a), .done_b(done_b),
        .frame_tick(frame_tick), .resume_evt(resume_evt), .resume_mode(resume_mode),
        .low_speed(low_speed), .usb_dp(usb_dp), .usb_dm(usb_dm)
    );

    function automatic logic [7:0] map4(input logic [3:0] v);
        return {1'b0, v[3], 1'b0, v[2], 2'b00, v[1], v[0]};
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [3:0] ev, input logic wr, input logic [7:0] wd);
        done_a = ev[0]; done_b = ev[1]; frame_tick = ev[2]; resume_evt = ev[3];
        reg_wr = wr; reg_wdata = wd;
        cyc(1);
        done_a = 0; done_b = 0; frame_tick = 0; resume_evt = 0; reg_wr = 0; reg_wdata = '0;
    endtask

    task automatic line(input logic dp, input logic dm, input int n);
        usb_dp = dp; usb_dm = dm;
        cyc(n);
    endtask

    initial begin
        cyc(3);
        // R1: reset state, resume mode
        chk("R1 reset status", status_rdata, 8'h00);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);
        resume_mode = 0; cyc(1);
        chk("R1 R9 SE0 no device", status_rdata, 8'h40);
        resume_mode = 1; cyc(1);
        rst_n = 1; cyc(2);

        // R2 R3 R4 R8 R11 R12: events then write-1 clear sweep
        for (int ev = 0; ev < 16; ev++) begin
            for (int cm = 0; cm < 16; cm++) begin
                pulse(4'h0, 1, 8'hFF);
                pulse(ev[3:0], 0, 8'h00);
                chk("R2 R3 R8 set", status_rdata, map4(ev[3:0]));
                chk("R12 irq set", {7'b0, irq}, {7'b0, ev != 0});
                pulse(4'h0, 1, map4(cm[3:0]) | 8'h8C);
                chk("R4 R11 clear", status_rdata, map4(ev[3:0] & ~cm[3:0]));
                chk("R12 irq after clear", {7'b0, irq}, {7'b0, (ev & ~cm) != 0});
            end
        end

        // R5: event and clear in same cycle
        for (int ev = 0; ev < 16; ev++) begin
            for (int cm = 0; cm < 16; cm++) begin
                pulse(4'hF, 0, 8'h00);
                pulse(ev[3:0], 1, map4(cm[3:0]));
                chk("R5 event wins", status_rdata, map4(~cm[3:0] | ev[3:0]));
            end
        end
        pulse(4'h0, 1, 8'hFF);

        // R9: presence mode ignores resume_evt
        resume_mode = 0; cyc(1);
        pulse(4'h8, 0, 8'h00);
        chk("R9 resume ignored", status_rdata, 8'h40);
        chk("R9 irq quiet", {7'b0, irq}, 8'h00);

        // R6 R10: full-speed attach (J = dp1 dm0)
        line(1, 0, 12);
        chk("R6 R9 R10 fs attach", status_rdata, 8'hA0);
        pulse(4'h0, 1, 8'h20);
        chk("R4 clear attach", status_rdata, 8'h80);
        // R6: detach
        line(0, 0, 12);
        chk("R6 fs detach", status_rdata, 8'h60);
        pulse(4'h0, 1, 8'h20);
        // R7: glitch shorter than filter window
        line(1, 0, STABLE - 1);
        line(0, 0, 12);
        chk("R7 glitch ignored", status_rdata, 8'h40);
        // R7: SE0 -> K -> J gives no event
        line(0, 1, 12);
        chk("R7 K not idle", status_rdata, 8'h00);
        line(1, 0, 12);
        chk("R7 K to J no event", status_rdata, 8'h80);
        line(0, 0, 12);
        pulse(4'h0, 1, 8'h20);
        // R6: low-speed attach (J = dp0 dm1)
        low_speed = 1; cyc(2);
        line(0, 1, 12);
        chk("R6 ls attach", status_rdata, 8'h20);
        chk("R12 irq cable", {7'b0, irq}, 8'h01);
        pulse(4'h0, 1, 8'h20);
        // R10: D+ follows after two clocks
        line(1, 1, 1);
        chk("R10 dp not yet", {7'b0, status_rdata[7]}, 8'h00);
        cyc(2);
        chk("R10 dp live", {7'b0, status_rdata[7]}, 8'h01);
        done_flag = 1;
    end

    initial begin
        for (int i = 0; i < 150000; i++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule